// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block rounds a binary mantissa under one of four rounding directions. It is purely combinational. The incoming mantissa carries two extra low-order bits below the kept field, a guard bit and a round bit. A separate sticky input stands for every bit discarded further down. The sign of the value and a 2-bit direction code complete the inputs.

The block removes the guard and round bits and decides whether the kept field must be bumped by one. It drives the result, one bit wider than the kept field, so that a carry out of the top bit stays visible. It also raises a flag when it rounded up and a flag when the value was not exact. A fourth output tells an overflow handler whether a result too large for the target format should become infinity or the largest finite magnitude.

Renormalisation after a carry, exponent adjustment and packing belong to the caller. The kept width is set by a parameter, and a second parameter selects a rippled or an adder-based increment.

Top module: `round_dir_unit`

## Requirements
- R1: When guard (mant_i[0+1]), round (mant_i[0]) and sticky_i are all 0, the result equals the kept field mant_i[MANT_W-1:2] with a 0 above it, and both rounded_up_o and inexact_o are 0, in every direction.
- R2: When any of guard, round or sticky_i is 1, inexact_o is 1 in every direction, including the cases where no increment happens.
- R3: With mode_i = 0 (nearest), the kept field is incremented only if guard is 1 and at least one of round, sticky_i or the kept LSB is 1, so exact ties go to the even value.
- R4: With mode_i = 1 (toward zero), the kept field is never incremented, whatever the sign and low bits.
- R5: With mode_i = 2 (toward plus infinity), the kept field is incremented exactly when the value is inexact and sign_i is 0.
- R6: With mode_i = 3 (toward minus infinity), the kept field is incremented exactly when the value is inexact and sign_i is 1.
- R7: mant_o equals the zero-extended kept field plus rounded_up_o, with the carry fully propagated. An all-ones kept field that rounds up gives mant_o with only its top bit set, and this value is not renormalised.
- R8: ovf_to_inf_o is 1 in nearest mode, 0 in toward-zero mode, equal to !sign_i toward plus infinity and equal to sign_i toward minus infinity. It does not depend on the mantissa or sticky_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mant_i | input | MANT_W (26) | Mantissa: kept field in the upper bits, guard in bit 1, round in bit 0 |
| sticky_i | input | 1 | OR of every bit discarded below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Direction: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity |
| mant_o | output | MANT_W-1 (25) | Kept field after rounding, with the carry bit on top |
| rounded_up_o | output | 1 | The kept field was incremented |
| inexact_o | output | 1 | Guard, round or sticky was set |
| ovf_to_inf_o | output | 1 | An overflowing result becomes infinity (1) or the largest finite magnitude (0) |

## Verification
The immediate assertions check, for every input value the bench applies, that exact inputs never round and never flag inexact, that a lost bit always raises inexact, that toward-zero never increments, that an increment only happens on an inexact value, and that the output is the kept field plus the rounded-up flag. The overflow-direction truth table is also asserted. The bench's scenarios are needed to show the choices that depend on the direction: the tie-to-even cases in nearest mode, the effect of the sign in the two infinite directions, and the carry that runs through an all-ones kept field. A random sweep then compares every output against a model built from the requirements.

// File: rtl/round_dir_pkg.sv
`timescale 1ns/1ps
package round_dir_pkg;

  typedef enum logic [1:0] {
    RD_NEAREST = 2'd0,
    RD_ZERO    = 2'd1,
    RD_POS_INF = 2'd2,
    RD_NEG_INF = 2'd3
  } rd_mode_e;

  localparam int unsigned LOW_BITS = 2;

  typedef struct packed {
    logic guard;
    logic rnd;
    logic sticky;
  } rd_lost_t;

endpackage

// File: rtl/round_dir_decide.sv
`timescale 1ns/1ps
module round_dir_decide
  import round_dir_pkg::*;
(
  input  rd_mode_e mode_i,
  input  logic     sign_i,
  input  logic     keep_lsb_i,
  input  rd_lost_t lost_i,
  output logic     bump_o,
  output logic     inexact_o
);

  logic any_lost;

  always_comb begin
    any_lost = lost_i.guard | lost_i.rnd | lost_i.sticky;
    bump_o   = 1'b0;
    unique case (mode_i)
      RD_NEAREST: bump_o = lost_i.guard & (lost_i.rnd | lost_i.sticky | keep_lsb_i);
      RD_ZERO:    bump_o = 1'b0;
      RD_POS_INF: bump_o = any_lost & ~sign_i;
      RD_NEG_INF: bump_o = any_lost & sign_i;
      default:    bump_o = 1'b0;
    endcase
    inexact_o = any_lost;
  end

  // A bump is only legal when something was discarded (R1)
  always_comb begin
    assert_bump_needs_loss_R1: assert (!bump_o || inexact_o)
      else $error("bump without discarded bits");
    // Toward zero never bumps (R4)
    assert_rtz_no_bump_R4: assert (!(mode_i == RD_ZERO && bump_o))
      else $error("toward-zero bumped");
  end

endmodule

// File: rtl/round_dir_incr.sv
`timescale 1ns/1ps
module round_dir_incr #(
  parameter int unsigned KEEP_W      = 24,
  parameter int unsigned CARRY_STYLE = 0,
  localparam int unsigned OUT_W      = KEEP_W + 1
) (
  input  logic [KEEP_W-1:0] keep_i,
  input  logic              bump_i,
  output logic [OUT_W-1:0]  sum_o
);

  generate
    if (CARRY_STYLE == 0) begin : g_ripple
      logic [KEEP_W:0] carry;
      assign carry[0] = bump_i;
      for (genvar b = 0; b < KEEP_W; b++) begin : g_bit
        assign sum_o[b]     = keep_i[b] ^ carry[b];
        assign carry[b + 1] = keep_i[b] & carry[b];
      end
      assign sum_o[KEEP_W] = carry[KEEP_W];
    end else begin : g_adder
      assign sum_o = {1'b0, keep_i} + {{KEEP_W{1'b0}}, bump_i};
    end
  endgenerate

  // Carry on top only when every kept bit was 1 and a bump happened (R7)
  always_comb begin
    assert_carry_top_R7: assert (!sum_o[KEEP_W] || (bump_i && (&keep_i)))
      else $error("unexpected carry out");
  end

endmodule

// File: rtl/round_dir_ovf.sv
`timescale 1ns/1ps
module round_dir_ovf
  import round_dir_pkg::*;
(
  input  rd_mode_e mode_i,
  input  logic     sign_i,
  output logic     to_inf_o
);

  always_comb begin
    to_inf_o = 1'b1;
    unique case (mode_i)
      RD_NEAREST: to_inf_o = 1'b1;
      RD_ZERO:    to_inf_o = 1'b0;
      RD_POS_INF: to_inf_o = ~sign_i;
      RD_NEG_INF: to_inf_o = sign_i;
      default:    to_inf_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/round_dir_unit.sv
`timescale 1ns/1ps
module round_dir_unit
  import round_dir_pkg::*;
#(
  parameter int unsigned MANT_W      = 26,
  parameter int unsigned CARRY_STYLE = 0,
  localparam int unsigned KEEP_W     = MANT_W - LOW_BITS,
  localparam int unsigned OUT_W      = KEEP_W + 1
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [OUT_W-1:0]  mant_o,
  output logic              rounded_up_o,
  output logic              inexact_o,
  output logic              ovf_to_inf_o
);

  logic [KEEP_W-1:0] keep;
  rd_lost_t          lost;
  rd_mode_e          mode;
  logic              bump;

  assign keep        = mant_i[MANT_W-1:LOW_BITS];
  assign lost.guard  = mant_i[1];
  assign lost.rnd    = mant_i[0];
  assign lost.sticky = sticky_i;
  assign mode        = rd_mode_e'(mode_i);

  round_dir_decide u_decide (
    .mode_i     (mode),
    .sign_i     (sign_i),
    .keep_lsb_i (keep[0]),
    .lost_i     (lost),
    .bump_o     (bump),
    .inexact_o  (inexact_o)
  );

  round_dir_incr #(
    .KEEP_W      (KEEP_W),
    .CARRY_STYLE (CARRY_STYLE)
  ) u_incr (
    .keep_i (keep),
    .bump_i (bump),
    .sum_o  (mant_o)
  );

  round_dir_ovf u_ovf (
    .mode_i   (mode),
    .sign_i   (sign_i),
    .to_inf_o (ovf_to_inf_o)
  );

  assign rounded_up_o = bump;

  always_comb begin
    // Exact input passes through untouched (R1)
    assert_exact_pass_R1: assert ((mant_i[1] | mant_i[0] | sticky_i) ||
                                  (!inexact_o && !rounded_up_o && mant_o == {1'b0, keep}))
      else $error("exact input altered");
    // Any lost bit flags inexact (R2)
    assert_lost_inexact_R2: assert (!(mant_i[1] | mant_i[0] | sticky_i) || inexact_o)
      else $error("inexact not raised");
    // Output is kept field plus the flag (R7)
    assert_sum_R7: assert (mant_o == ({1'b0, keep} + {{KEEP_W{1'b0}}, rounded_up_o}))
      else $error("sum mismatch");
    // Overflow direction in the two fixed modes (R8)
    assert_ovf_fixed_R8: assert ((mode_i != 2'd0 || ovf_to_inf_o) &&
                                 (mode_i != 2'd1 || !ovf_to_inf_o))
      else $error("overflow direction wrong");
  end

endmodule

// File: tb/round_dir_unit_bench.sv
`timescale 1ns/1ps
module round_dir_unit_bench;

  localparam int MW = 26;
  localparam int KW = MW - 2;
  localparam int OW = KW + 1;

  logic clk;
  logic rst_n;
  logic [MW-1:0] mant_i;
  logic          sticky_i, sign_i;
  logic [1:0]    mode_i;
  logic [OW-1:0] mant_o;
  logic          rounded_up_o, inexact_o, ovf_to_inf_o;

  int checks = 0;
  int errors = 0;

  round_dir_unit u_round_dir_unit (
    .mant_i, .sticky_i, .sign_i, .mode_i,
    .mant_o, .rounded_up_o, .inexact_o, .ovf_to_inf_o
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [MW-1:0] m, input logic s, input logic sg, input logic [1:0] md);
    @(negedge clk);
    mant_i = m; sticky_i = s; sign_i = sg; mode_i = md;
    #2;
  endtask

  // Model derived from the requirements
  task automatic expect_all(input string tag);
    logic [KW-1:0] kp;
    logic g, r, any, inc, inf;
    kp = mant_i[MW-1:2]; g = mant_i[1]; r = mant_i[0];
    any = g | r | sticky_i;
    case (mode_i)
      2'd0: begin inc = g & (r | sticky_i | kp[0]); inf = 1'b1; end
      2'd1: begin inc = 1'b0; inf = 1'b0; end
      2'd2: begin inc = any & ~sign_i; inf = ~sign_i; end
      default: begin inc = any & sign_i; inf = sign_i; end
    endcase
    check({tag, " mant"}, 64'(mant_o), 64'({1'b0, kp}) + 64'(inc));
    check({tag, " up"}, 64'(rounded_up_o), 64'(inc));
    check({tag, " inexact"}, 64'(inexact_o), 64'(any));
    check({tag, " ovf"}, 64'(ovf_to_inf_o), 64'(inf));
  endtask

  task automatic t_reset;
    apply('0, 1'b0, 1'b0, 2'd0);
    check("R1 reset mant", 64'(mant_o), 64'd0);
    check("R1 reset inexact", 64'(inexact_o), 64'd0);
    check("R8 reset ovf", 64'(ovf_to_inf_o), 64'd1);
  endtask

  task automatic t_exact;
    for (int md = 0; md < 4; md++) begin
      apply({24'hABCDE1, 2'b00}, 1'b0, md[0], 2'(md));
      check("R1 exact mant", 64'(mant_o), 64'h0ABCDE1);
      check("R1 exact up", 64'(rounded_up_o), 64'd0);
      check("R1 exact inexact", 64'(inexact_o), 64'd0);
    end
  endtask

  task automatic t_nearest;
    apply({24'h000010, 2'b10}, 1'b0, 1'b0, 2'd0);
    check("R3 tie even stays", 64'(mant_o), 64'h10);
    check("R2 tie inexact", 64'(inexact_o), 64'd1);
    apply({24'h000011, 2'b10}, 1'b0, 1'b0, 2'd0);
    check("R3 tie odd bumps", 64'(mant_o), 64'h12);
    apply({24'h000010, 2'b11}, 1'b0, 1'b1, 2'd0);
    check("R3 above half", 64'(mant_o), 64'h11);
    apply({24'h000010, 2'b10}, 1'b1, 1'b0, 2'd0);
    check("R3 sticky breaks tie", 64'(mant_o), 64'h11);
    apply({24'h000011, 2'b01}, 1'b1, 1'b0, 2'd0);
    check("R3 below half", 64'(mant_o), 64'h11);
    check("R2 below half inexact", 64'(inexact_o), 64'd1);
  endtask

  task automatic t_zero;
    for (int sg = 0; sg < 2; sg++) begin
      apply({24'h123456, 2'b11}, 1'b1, sg[0], 2'd1);
      check("R4 toward zero mant", 64'(mant_o), 64'h123456);
      check("R4 toward zero up", 64'(rounded_up_o), 64'd0);
      check("R2 toward zero inexact", 64'(inexact_o), 64'd1);
    end
  endtask

  task automatic t_plus;
    apply({24'h000100, 2'b00}, 1'b1, 1'b0, 2'd2);
    check("R5 positive bumps", 64'(mant_o), 64'h101);
    apply({24'h000100, 2'b01}, 1'b0, 1'b1, 2'd2);
    check("R5 negative stays", 64'(mant_o), 64'h100);
    apply({24'h000100, 2'b00}, 1'b0, 1'b0, 2'd2);
    check("R5 exact positive stays", 64'(mant_o), 64'h100);
  endtask

  task automatic t_minus;
    apply({24'h000200, 2'b01}, 1'b0, 1'b1, 2'd3);
    check("R6 negative bumps", 64'(mant_o), 64'h201);
    apply({24'h000200, 2'b10}, 1'b1, 1'b0, 2'd3);
    check("R6 positive stays", 64'(mant_o), 64'h200);
  endtask

  task automatic t_carry;
    apply({24'hFFFFFF, 2'b11}, 1'b0, 1'b0, 2'd0);
    check("R7 carry out", 64'(mant_o), 64'h1000000);
    check("R7 carry up", 64'(rounded_up_o), 64'd1);
    apply({24'h00FFFF, 2'b00}, 1'b1, 1'b1, 2'd3);
    check("R7 partial carry", 64'(mant_o), 64'h010000);
  endtask

  task automatic t_ovf;
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++) begin
        apply({24'hFFFFFF, 2'b10}, sg[0], sg[0], 2'(md));
        expect_all("R8 ovf table");
      end
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 1500; n++) begin
      apply(MW'($urandom), 1'($urandom), 1'($urandom), 2'(n));
      expect_all("R3 R5 R6 R7 sweep");
    end
  endtask

  initial begin
    mant_i = '0; sticky_i = 1'b0; sign_i = 1'b0; mode_i = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exact();
    t_nearest();
    t_zero();
    t_plus();
    t_minus();
    t_carry();
    t_ovf();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule